// File: doc/BRIEF.md
# SPI Register-Access Slave

This block lets an external SPI host read and write a file of 8-bit registers inside the chip. Every access is one frame of exactly sixteen serial clocks, delimited by the active-low chip select. The host shifts in a command byte (read/write flag plus a 5-bit register address) followed by a data byte. At the same time the block shifts out a status byte and then the current contents of the addressed register.

Host signals are brought into the system clock domain through two-flop synchronizers, and all edges are detected there. The block counts the sampling edges of each frame. A write takes effect only when chip select returns high after exactly sixteen bits. Any frame of another length is discarded and leaves a sticky error flag in the status register. The chip reads the register contents through a flat output bus.

SPI mode: the clock idles low, MOSI is sampled on the falling edge of SCLK, and MISO changes after the rising edge. Both bytes are sent MSB first. Frame bit 15 (first sent) is reserved, bit 14 is the read flag (1 = read), bits 13:9 are the register address, bit 8 is unused, and bits 7:0 carry write data.

Top module: `spi_regfile_slave`

## Requirements
- R1: After reset, every register and the status byte read as zero on `reg_q`, and `host_miso_oe` is low.
- R2: A 16-bit frame with bit 14 = 0 and a nonzero address in bits 13:9 stores frame bits 7:0 into that register when chip select rises. Register `a` appears on `reg_q[8a+7:8a]`.
- R3: A frame whose count of SCLK falling edges is not exactly 16 (including zero) changes no register.
- R4: Such a mis-sized frame sets status bit 0. That bit stays set through later valid frames that are not status reads.
- R5: A 16-bit frame with bit 14 = 1 and address 0 clears status bit 0 when chip select rises. A mis-sized frame of the same form leaves the bit set.
- R6: The first eight bits shifted out on MISO are the status byte as it stood when chip select fell, MSB first. The status byte is bit 0 = error flag and bits 7:1 = 0.
- R7: The second eight bits shifted out are the addressed register's contents before any commit of the same frame. A write frame therefore returns the old value.
- R8: SCLK may stop for an arbitrary time between the two bytes while chip select stays low, with no effect on the result.
- R9: Address 0 is the read-only status register. A write to it changes nothing.
- R10: `host_miso_oe` is high while chip select is low and low while it is high, each after the synchronizer latency.
- R11: Frame bit 15 is ignored. On a read, bits 8:0 are ignored and no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 10x the SCLK rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_sclk | input | 1 | Serial clock from the host, idle low |
| host_cs_n | input | 1 | Active-low frame select from the host |
| host_mosi | input | 1 | Serial data from the host |
| host_miso | output | 1 | Serial data to the host |
| host_miso_oe | output | 1 | Output enable for the MISO pad driver |
| reg_q | output | 256 | All 32 registers, register a in bits 8a+7:8a, status at 0 |

## Verification
Two functions can coincide on one register in one frame. The first is the readback of a register and the commit of a write to it: the bench writes a register whose value it already knows and expects the old value in the second byte, with the new value on `reg_q` afterwards. The second is the setting and clearing of the error flag in one chip-select rise: a 15-bit status read, which carries the clear command in a mis-sized frame, must leave the flag set. A full-length status read must return the flag in the first byte and clear it only afterwards. A scoreboard compares each frame's MISO stream against the value predicted from a register model, and `reg_q` is compared against the model after every frame.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  // Register and frame geometry. The command byte is laid out as
  // {reserved, read flag, address, unused}, so DATA_W must equal ADDR_W + 3.
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 5;
  localparam int NREG    = 1 << ADDR_W;
  localparam int FRAME_W = 2 * DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int SYNC_N  = 2;

  // Decoded view of the frame presented to the register file at commit time.
  typedef struct packed {
    logic              ok;     // exactly FRAME_W sampling edges seen
    logic              rd;     // 1 = read
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } frame_t;
endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= RST_VAL;
        else        stage[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= RST_VAL;
        else        stage[g] <= stage[g-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_rf_frame.sv
module spi_rf_frame
  import spi_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output frame_t            frame_o,
  output logic              commit_o,
  output logic              miso_o,
  output logic              miso_oe_o
);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(DATA_W - 1);

  logic               sclk_d, csn_d;
  logic [CNT_W-1:0]   fall_cnt, fall_cnt_n;
  logic [CNT_W-1:0]   rise_cnt, rise_cnt_n;
  logic [FRAME_W-1:0] rx_sr, rx_n;
  logic [DATA_W-1:0]  cmd_q, cmd_n;
  logic [DATA_W-1:0]  tx_sr, tx_n;
  logic               miso_q, miso_n;
  logic               oe_q;

  logic sclk_rise, sclk_fall, cs_start, cs_end, in_frame;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign cs_start  = ~csn_s & csn_d;
  assign cs_end    = csn_s & ~csn_d;
  assign in_frame  = ~csn_s;

  // Next-state logic: count edges, shift in on falls, shift out on rises.
  always_comb begin
    fall_cnt_n = fall_cnt;
    rise_cnt_n = rise_cnt;
    rx_n       = rx_sr;
    cmd_n      = cmd_q;
    tx_n       = tx_sr;
    miso_n     = miso_q;
    if (cs_start) begin
      fall_cnt_n = '0;
      rise_cnt_n = '0;
      tx_n       = status_i;              // status snapshot at frame start
      miso_n     = status_i[DATA_W-1];
    end else if (in_frame) begin
      if (sclk_fall) begin
        if (fall_cnt != CNT_SAT)  fall_cnt_n = fall_cnt + 1'b1;
        if (fall_cnt < CNT_FULL)  rx_n = {rx_sr[FRAME_W-2:0], mosi_s};
        if (fall_cnt == CNT_CMD)  cmd_n = {rx_sr[DATA_W-2:0], mosi_s};
      end
      if (sclk_rise) begin
        if (rise_cnt != CNT_SAT) rise_cnt_n = rise_cnt + 1'b1;
        if (rise_cnt == CNT_BYTE) begin
          miso_n = rd_data_i[DATA_W-1];
          tx_n   = {rd_data_i[DATA_W-2:0], 1'b0};
        end else begin
          miso_n = tx_sr[DATA_W-1];
          tx_n   = {tx_sr[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      csn_d    <= 1'b1;
      fall_cnt <= '0;
      rise_cnt <= '0;
      rx_sr    <= '0;
      cmd_q    <= '0;
      tx_sr    <= '0;
      miso_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      csn_d    <= csn_s;
      fall_cnt <= fall_cnt_n;
      rise_cnt <= rise_cnt_n;
      rx_sr    <= rx_n;
      cmd_q    <= cmd_n;
      tx_sr    <= tx_n;
      miso_q   <= miso_n;
      oe_q     <= in_frame;
    end
  end

  assign frame_o.ok    = (fall_cnt == CNT_FULL);
  assign frame_o.rd    = cmd_q[DATA_W-2];
  assign frame_o.addr  = cmd_q[ADDR_W:1];
  assign frame_o.wdata = rx_sr[DATA_W-1:0];
  assign commit_o      = cs_end;
  assign miso_o        = miso_q;
  assign miso_oe_o     = oe_q;

  // The edge counter saturates and never wraps, so no length aliases to 16.
  p_cnt_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_cnt <= CNT_SAT);

  // Received bits hold still whenever SCLK does not fall (pause tolerance).
  p_hold_in_pause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(rx_sr));

  // A new frame restarts the length count.
  p_cnt_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_start |=> (fall_cnt == '0));

  // The output driver is off once chip select has been high for two samples.
  p_oe_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s && $past(csn_s) |-> !miso_oe_o);
endmodule

// File: rtl/spi_rf_regs.sv
module spi_rf_regs
  import spi_rf_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit_i,
  input  frame_t                   frame_i,
  output logic [DATA_W-1:0]        status_o,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic [NREG*DATA_W-1:0]   regs_o
);
  logic              ferr_q, ferr_n;
  logic              good_wr, stat_clr;
  logic [DATA_W-1:0] regv [NREG];

  assign good_wr  = commit_i & frame_i.ok & ~frame_i.rd;
  assign stat_clr = commit_i & frame_i.ok &  frame_i.rd & (frame_i.addr == '0);

  // Sticky error flag: a bad frame wins over any clear.
  always_comb begin
    ferr_n = ferr_q;
    if (commit_i && !frame_i.ok) ferr_n = 1'b1;
    else if (stat_clr)           ferr_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ferr_q <= 1'b0;
    else        ferr_q <= ferr_n;
  end

  assign status_o = {{(DATA_W-1){1'b0}}, ferr_q};
  assign regv[0]  = status_o;

  for (genvar a = 1; a < NREG; a++) begin : g_reg
    logic [DATA_W-1:0] stor;
    logic              wen;
    assign wen = good_wr & (frame_i.addr == ADDR_W'(a));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   stor <= '0;
      else if (wen) stor <= frame_i.wdata;
    end
    assign regv[a] = stor;
  end

  for (genvar a = 0; a < NREG; a++) begin : g_flat
    assign regs_o[a*DATA_W +: DATA_W] = regv[a];
  end

  assign rd_data_o = regv[frame_i.addr];

  p_bad_frame_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i && !frame_i.ok |=> ferr_q);

  p_bad_frame_keeps_regs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i && !frame_i.ok |=> $stable(regs_o[NREG*DATA_W-1:DATA_W]));

  p_status_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i && frame_i.ok && frame_i.rd && frame_i.addr == '0 |=> !ferr_q);

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_q && !commit_i |=> ferr_q);

  p_read_no_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i && frame_i.rd |=> $stable(regs_o[NREG*DATA_W-1:DATA_W]));
endmodule

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave
  import spi_rf_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_sclk,
  input  logic                   host_cs_n,
  input  logic                   host_mosi,
  output logic                   host_miso,
  output logic                   host_miso_oe,
  output logic [NREG*DATA_W-1:0] reg_q
);
  logic              rst_sync_n;
  logic              sclk_s, csn_s, mosi_s;
  logic              commit;
  frame_t            frame;
  logic [DATA_W-1:0] status, rd_data;

  // Reset: asserted at once, released on a clock edge.
  spi_rf_sync #(.W(1), .STAGES(SYNC_N), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n));

  spi_rf_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b010)) u_pin_sync (
    .clk(clk), .rst_n(rst_sync_n),
    .d({host_sclk, host_cs_n, host_mosi}),
    .q({sclk_s, csn_s, mosi_s}));

  spi_rf_frame u_frame (
    .clk(clk), .rst_n(rst_sync_n),
    .sclk_s(sclk_s), .csn_s(csn_s), .mosi_s(mosi_s),
    .status_i(status), .rd_data_i(rd_data),
    .frame_o(frame), .commit_o(commit),
    .miso_o(host_miso), .miso_oe_o(host_miso_oe));

  spi_rf_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .commit_i(commit), .frame_i(frame),
    .status_o(status), .rd_data_o(rd_data), .regs_o(reg_q));
endmodule

// File: tb/tb_spi_regfile_slave.sv
module tb_spi_regfile_slave;
  import spi_rf_pkg::*;

  localparam int HP = 8;  // SCLK half period in system clocks

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic rst_n, sclk, cs_n, mosi;
  logic miso, miso_oe;
  logic [NREG*DATA_W-1:0] reg_q;

  spi_regfile_slave dut (
    .clk(clk), .rst_n(rst_n), .host_sclk(sclk), .host_cs_n(cs_n),
    .host_mosi(mosi), .host_miso(miso), .host_miso_oe(miso_oe), .reg_q(reg_q));

  int checks = 0, fails = 0;
  bit done = 0, armed = 0;
  logic [7:0] model [NREG];
  logic       ferr_m;

  typedef struct { int n; logic [15:0] w; string tag; } exp_t;
  typedef struct { int n; logic [31:0] sr; } got_t;
  exp_t exp_q[$];
  got_t got_q[$];
  logic [31:0] cap_sr;
  int          cap_n;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // Host-side capture of MISO at each SCLK falling edge.
  always @(negedge cs_n) begin cap_sr = '0; cap_n = 0; end
  always @(negedge sclk) if (!cs_n) begin cap_sr = {cap_sr[30:0], miso}; cap_n++; end
  always @(posedge cs_n) if (armed) got_q.push_back('{cap_n, cap_sr});

  // Scoreboard monitor.
  initial begin : monitor
    got_t g; exp_t e; int m; logic [31:0] gv, ev, mask;
    forever begin
      wait (got_q.size() > 0);
      g = got_q.pop_front();
      e = exp_q.pop_front();
      m  = (e.n > 16) ? 16 : e.n;
      gv = (g.n > 16) ? (g.sr >> (g.n - 16)) : g.sr;
      ev = {16'h0, e.w} >> (16 - m);
      mask = (m == 0) ? 32'h0 : ((32'h1 << m) - 1);
      if (m > 0) chk(((gv ^ ev) & mask) == 0, e.tag, "miso stream", gv & mask, ev & mask);
    end
  end

  function automatic logic [15:0] mk(bit r15, bit rd, int a, bit b8, logic [7:0] d);
    return {r15, rd, 5'(a), b8, d};
  endfunction

  task automatic check_regs(input string req);
    for (int a = 0; a < NREG; a++) begin
      logic [7:0] e;
      e = (a == 0) ? {7'b0, ferr_m} : model[a];
      chk(reg_q[a*8 +: 8] == e, req, $sformatf("reg_q[%0d]", a), 32'(reg_q[a*8 +: 8]), 32'(e));
    end
  endtask

  task automatic frame(input int n, input logic [15:0] w, input int pause, input string tag);
    logic [7:0] st, rv; int a;
    st = {7'b0, ferr_m};
    a  = int'(w[13:9]);
    rv = (a == 0) ? st : model[a];
    exp_q.push_back('{n, {st, rv}, tag});
    @(negedge clk) cs_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(miso_oe == 1'b1, "R10", "oe in frame", 32'(miso_oe), 32'h1);
    for (int i = 0; i < n; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'b0;
      sclk = 1'b1; repeat (HP) @(negedge clk);
      sclk = 1'b0; repeat (HP) @(negedge clk);
      if (i == 7 && pause > 0) repeat (pause) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(miso_oe == 1'b0, "R10", "oe idle", 32'(miso_oe), 32'h0);
    if (n == 16) begin
      if (!w[14] && a != 0) model[a] = w[7:0];
      if (w[14] && a == 0)  ferr_m = 1'b0;
    end else begin
      ferr_m = 1'b1;
    end
    check_regs(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
    ferr_m = 1'b0;
    for (int a = 0; a < NREG; a++) model[a] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(reg_q == '0, "R1", "reset regs", 32'(reg_q[31:0]), 32'h0);
    chk(miso_oe == 1'b0, "R1", "reset oe", 32'(miso_oe), 32'h0);
    armed = 1;

    frame(16, mk(0, 0, 3,  0, 8'hA5), 0, "R2 write r3");
    frame(16, mk(0, 0, 31, 0, 8'h3C), 0, "R2 write r31");
    frame(16, mk(0, 0, 1,  0, 8'hFF), 0, "R2 write r1");
    frame(16, mk(0, 1, 3,  1, 8'hFF), 0, "R11 read with junk bits");
    frame(16, mk(0, 0, 3,  0, 8'h5A), 0, "R7 write returns old value");
    frame(16, mk(0, 0, 0,  0, 8'h77), 0, "R9 write to status ignored");
    frame(15, mk(0, 0, 5,  0, 8'h12), 0, "R3 short frame discarded");
    frame(16, mk(0, 1, 5,  0, 8'h00), 0, "R6 status byte shows error");
    frame(17, mk(0, 0, 6,  0, 8'h34), 0, "R3 long frame discarded");
    frame(0,  16'h0000,               0, "R3 empty frame");
    frame(8,  mk(0, 0, 2,  0, 8'h00), 0, "R4 byte frame sets flag");
    frame(16, mk(0, 0, 4,  0, 8'h44), 0, "R4 flag survives write");
    frame(15, mk(0, 1, 0,  0, 8'h00), 0, "R5 short status read keeps flag");
    frame(16, mk(0, 1, 0,  0, 8'h00), 0, "R5 status read clears");
    frame(16, mk(0, 1, 0,  0, 8'h00), 0, "R5 status after clear");
    frame(16, mk(0, 0, 7,  0, 8'hC3), 300, "R8 paused write");
    frame(16, mk(0, 1, 7,  0, 8'h00), 1000, "R8 paused read");
    frame(16, mk(1, 0, 9,  1, 8'h81), 0, "R11 reserved bit ignored");
    frame(16, mk(0, 1, 9,  0, 8'h00), 0, "R2 readback r9");

    repeat (20) @(negedge clk);
    wait (got_q.size() == 0);
    chk(exp_q.size() == 0, "R6", "scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule